// File: doc/BRIEF.md
# Output Compare Timer with Master-Match Counter Reset

This block is a 16-bit up-counter that advances once every 2^N bus cycles. It has eight compare channels. Each channel is either idle (input-capture mode, whose edge logic lives elsewhere) or an output compare. An output compare drives its own pin when the counter reaches the channel's value. The pin action is chosen per channel: leave the pin alone, toggle it, clear it or set it.

The highest channel is the master. A per-channel broadcast mask lets a master match force the channel's pin to a programmed level. The broadcast respects the channel's own "leave alone" setting. An optional mode wraps the counter back to zero after it reaches the master value, which gives a programmable period.

Software reaches the block through a flat register port: a write strobe, an address, write data, and read data that is decoded combinationally. Match flags and pin levels are also brought out as ports.

Top module: `timer_oc`

## Requirements
- R1: After reset the counter reads 0, all match flags are 0 and all pins are 0.
- R2: The register map is: 0 control (bit 0 run enable, bit 1 wrap-on-master, bits 4:2 prescale select N), 1 channel mode bits (1 = output compare), 2 actions (two bits per channel, channel i at bits 2i+1:2i), 3 broadcast mask, 4 broadcast levels, 5 match flags, 6 counter (read only), 8 to 15 compare values of channels 0 to 7.
- R3: While enabled in free-running mode the counter advances by exactly one every 2^N bus cycles. While disabled it holds its value.
- R4: With wrap-on-master set and a nonzero master value, the counter climbs from 0 to the master value. It stays at that value for exactly one bus cycle and then returns to 0, independent of the prescaler.
- R5: In wrap mode the period is the master value times 2^N, plus one bus cycle.
- R6: An output compare channel matches in the cycle its compare value is loaded into the counter, and sets its sticky flag. A channel whose mode bit is 0 never sets its flag and never moves its pin.
- R7: The action codes 01, 10 and 11 toggle, clear and set the pin on the channel's own match.
- R8: Action code 00 leaves the pin untouched, even when the channel's broadcast mask bit is set and the master matches.
- R9: A master match drives every masked, connected output compare pin to that channel's broadcast level bit.
- R10: When a channel's own match and the master broadcast fall in the same cycle, the broadcast level wins on a masked pin.
- R11: Writing 1 to a flag bit clears it. Writing 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr` |
| matchFlags | output | 8 | Sticky compare-match flags |
| pinOut | output | 8 | Per-channel compare pin levels |

## Verification
The bench samples the counter every cycle in wrap mode and measures how long the top value lasts. A design that honours the prescaler at the top would hold the master value for 2^N cycles instead of one. The pin period measured by the scoreboard would then grow past the master value times 2^N plus one.

The bench also places a disconnected channel under the broadcast mask with a broadcast level of 1. A design missing the gate would raise that pin.

A connected channel's own set action lands in the same cycle as the master clear. The pin must stay low there, and a wrong priority would leave it high.

Writes of 0 to the flag register must leave the flags set, which catches a plain overwrite.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int TMR_CH = 8;

  // per-cycle strobes from the register control to the datapath
  typedef struct packed {
    logic [TMR_CH-1:0] clrFlags;   // write-one-to-clear mask
    logic              restartPre; // control register was written
  } tmrStrobe_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = TMR_CH,
  parameter int PRE_W  = 3,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [CNT_W-1:0]     count,
  input  logic [NCH-1:0]       flags,
  output logic [CNT_W-1:0]     rdData,
  output tmrStrobe_t           strobe,
  output logic                 enable,
  output logic                 resetMode,
  output logic [PRE_W-1:0]     preSel,
  output logic [NCH-1:0]       ocMode,
  output logic [2*NCH-1:0]     action,
  output logic [NCH-1:0]       mask7,
  output logic [NCH-1:0]       level7,
  output logic [CNT_W-1:0]     cmpVal [NCH]
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(6);
  localparam int               CIDX_W = ADDR_W - 1;

  logic cmpSel;
  assign cmpSel = addr[ADDR_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      resetMode <= 1'b0;
      preSel    <= '0;
      ocMode    <= '0;
      action    <= '0;
      mask7     <= '0;
      level7    <= '0;
      for (int i = 0; i < NCH; i++) cmpVal[i] <= '0;
    end else if (wrEn) begin
      if (cmpSel) begin
        cmpVal[addr[CIDX_W-1:0]] <= wrData;
      end else begin
        case (addr)
          A_CTRL: begin
            enable    <= wrData[0];
            resetMode <= wrData[1];
            preSel    <= wrData[PRE_W+1:2];
          end
          A_MODE: ocMode <= wrData[NCH-1:0];
          A_ACT:  action <= wrData[2*NCH-1:0];
          A_MASK: mask7  <= wrData[NCH-1:0];
          A_LVL:  level7 <= wrData[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.clrFlags   = (wrEn && addr == A_FLAG) ? wrData[NCH-1:0] : '0;
    strobe.restartPre = wrEn && addr == A_CTRL;
  end

  always_comb begin
    rdData = '0;
    if (cmpSel) begin
      rdData = cmpVal[addr[CIDX_W-1:0]];
    end else begin
      case (addr)
        A_CTRL: rdData = CNT_W'({preSel, resetMode, enable});
        A_MODE: rdData = CNT_W'(ocMode);
        A_ACT:  rdData = CNT_W'(action);
        A_MASK: rdData = CNT_W'(mask7);
        A_LVL:  rdData = CNT_W'(level7);
        A_FLAG: rdData = CNT_W'(flags);
        A_CNT:  rdData = count;
        default: rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = TMR_CH,
  parameter int PRE_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tmrStrobe_t           strobe,
  input  logic                 enable,
  input  logic                 resetMode,
  input  logic [PRE_W-1:0]     preSel,
  input  logic [NCH-1:0]       ocMode,
  input  logic [2*NCH-1:0]     action,
  input  logic [NCH-1:0]       mask7,
  input  logic [NCH-1:0]       level7,
  input  logic [CNT_W-1:0]     cmpVal [NCH],
  output logic [CNT_W-1:0]     count,
  output logic [NCH-1:0]       flags,
  output logic [NCH-1:0]       pinOut
);

  localparam int PCNT_W = (1 << PRE_W) - 1;  // widest divide is 2^(PCNT_W)
  localparam int MASTER = NCH - 1;

  logic [PCNT_W-1:0] preCnt, preNext, preTop;
  logic [CNT_W-1:0]  countNext;
  logic              tick, atTop, load;
  logic [NCH-1:0]    hit, pinNext;

  // prescaler terminal value 2^N - 1
  assign preTop = ~({PCNT_W{1'b1}} << preSel);
  assign tick   = (preCnt == preTop);
  assign atTop  = resetMode && (cmpVal[MASTER] != '0) && (count == cmpVal[MASTER]);

  always_comb begin
    load      = 1'b0;
    countNext = count;
    preNext   = preCnt;
    if (enable) begin
      if (atTop) begin
        load      = 1'b1;
        countNext = '0;
        preNext   = '0;
      end else if (tick) begin
        load      = 1'b1;
        countNext = count + 1'b1;
        preNext   = '0;
      end else begin
        preNext   = preCnt + 1'b1;
      end
    end
    if (strobe.restartPre) preNext = '0;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic [1:0] act;
    logic       live;
    assign act     = action[2*i +: 2];
    assign live    = ocMode[i] && (act != 2'b00);
    assign hit[i]  = load && ocMode[i] && (countNext == cmpVal[i]);
    // master broadcast first, then own action
    assign pinNext[i] = !live                      ? pinOut[i] :
                        (mask7[i] && hit[MASTER])   ? level7[i] :
                        !hit[i]                     ? pinOut[i] :
                        (act == 2'b01)              ? ~pinOut[i] :
                                                      act[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= '0;
      flags  <= '0;
      pinOut <= '0;
    end else begin
      preCnt <= preNext;
      count  <= countNext;
      flags  <= (flags & ~strobe.clrFlags) | hit;
      pinOut <= pinNext;
    end
  end

endmodule

// File: rtl/timer_oc.sv
module timer_oc
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = TMR_CH,
  parameter int PRE_W  = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [NCH-1:0]    matchFlags,
  output logic [NCH-1:0]    pinOut
);

  tmrStrobe_t         strobe;
  logic               enable, resetMode;
  logic [PRE_W-1:0]   preSel;
  logic [NCH-1:0]     ocMode, mask7, level7;
  logic [2*NCH-1:0]   action;
  logic [CNT_W-1:0]   cmpVal [NCH];
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   cmpTop;

  assign cmpTop = cmpVal[NCH-1];

  tmr_ctrl #(.CNT_W(CNT_W), .NCH(NCH), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .count(count), .flags(matchFlags), .rdData(rdData), .strobe(strobe),
    .enable(enable), .resetMode(resetMode), .preSel(preSel), .ocMode(ocMode),
    .action(action), .mask7(mask7), .level7(level7), .cmpVal(cmpVal)
  );

  tmr_datapath #(.CNT_W(CNT_W), .NCH(NCH), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .enable(enable),
    .resetMode(resetMode), .preSel(preSel), .ocMode(ocMode), .action(action),
    .mask7(mask7), .level7(level7), .cmpVal(cmpVal), .count(count),
    .flags(matchFlags), .pinOut(pinOut)
  );

endmodule

// File: rtl/timer_oc_chk.sv
module timer_oc_chk #(
  parameter int CNT_W  = 16,
  parameter int NCH    = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wrData,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  cmp7,
  input logic              enable,
  input logic              resetMode,
  input logic [NCH-1:0]    ocMode,
  input logic [2*NCH-1:0]  action,
  input logic [NCH-1:0]    flags,
  input logic [NCH-1:0]    pinOut
);

  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(5);

  // R4: one cycle at the top value, then zero
  a_r4_wrap_after_top: assert property (@(posedge clk) disable iff (!rstN)
    (enable && resetMode && cmp7 != '0 && count == cmp7) |=> (count == '0));

  // R3: disabled counter holds
  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(count));

  // R3: away from the top the counter never jumps
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !(resetMode && cmp7 != '0 && count == cmp7)) |=>
      (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R8 and R6: disconnected or non-compare channel keeps its pin
    a_r8_pin_frozen: assert property (@(posedge clk) disable iff (!rstN)
      (!ocMode[i] || action[2*i +: 2] == 2'b00) |=> $stable(pinOut[i]));

    // R11: a flag only drops after a write of 1 to its bit
    a_r11_flag_clear_by_write: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flags[i]) |-> $past(wrEn && addr == FLAG_ADDR && wrData[i]));
  end

endmodule

bind timer_oc timer_oc_chk #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .count(count), .cmp7(cmpTop), .enable(enable), .resetMode(resetMode),
  .ocMode(ocMode), .action(action), .flags(matchFlags), .pinOut(pinOut)
);

// File: tb/timer_oc_tb.sv
module timer_oc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int A_CTRL = 0, A_MODE = 1, A_ACT = 2, A_MASK = 3, A_LVL = 4;
  localparam int A_FLAG = 5, A_CNT = 6, A_CMP = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  wire  [15:0] rdData;
  wire  [7:0]  matchFlags;
  wire  [7:0]  pinOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_oc u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .matchFlags(matchFlags), .pinOut(pinOut)
  );

  task automatic check(input string req, input int actual, input int expected);
    nChecks++;
    if (actual !== expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = a[3:0]; wrData = d[15:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = a[3:0];
    #1;
    v = int'(rdData);
  endtask

  task automatic waitCount(input int target);
    int v;
    v = -1;
    for (int k = 0; k < 500; k++) begin
      rd(A_CNT, v);
      if (v == target) return;
      @(negedge clk);
    end
    check("R4 counter reaches value", v, target);
  endtask

  // scoreboard: expected pin 7 toggle intervals
  int expPeriod[$];
  int cyc = 0;
  int lastEdge = -1;
  logic prevPin7 = 1'b0;

  always @(negedge clk) begin
    int e;
    cyc++;
    if (rstN && pinOut[7] !== prevPin7) begin
      if (expPeriod.size() > 0 && lastEdge >= 0) begin
        e = expPeriod.pop_front();
        check("R5 period (R7 toggle)", cyc - lastEdge, e);
      end
      lastEdge = cyc;
    end
    prevPin7 = pinOut[7];
  end

  task automatic expectPeriods(input int period, input int n);
    for (int k = 0; k < n; k++) expPeriod.push_back(period);
    for (int k = 0; k < 400 && expPeriod.size() > 0; k++) @(negedge clk);
    check("R5 all periods seen", expPeriod.size(), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int v, c1, c2, prev, run, maxV, run5, run2;
    bit seenChange;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CNT, v);  check("R1 count", v, 0);
    rd(A_FLAG, v); check("R1 flags", v, 0);
    check("R1 pins", int'(pinOut), 0);

    // R4/R5: wrap mode, master = 5, N = 1, channel 7 toggles
    wr(A_CMP + 7, 5);
    wr(A_MODE, 'h80);
    wr(A_ACT, 'h4000);
    wr(A_CTRL, 1 | 2 | (1 << 2));
    repeat (30) @(negedge clk);
    expectPeriods(11, 3);

    // R4 top dwell, R3 prescaled step length
    prev = -1; run = 0; maxV = 0; run5 = -1; run2 = -1; seenChange = 0;
    for (int k = 0; k < 60; k++) begin
      rd(A_CNT, v);
      if (v > maxV) maxV = v;
      if (v == prev) run++;
      else begin
        if (seenChange) begin
          if (prev == 5) run5 = run;
          if (prev == 2) run2 = run;
        end
        if (prev != -1) seenChange = 1;
        run = 1;
      end
      prev = v;
      @(negedge clk);
    end
    check("R4 top value lasts one cycle", run5, 1);
    check("R3 value lasts 2^N cycles", run2, 2);
    check("R4 counter never passes master", maxV, 5);

    // channel setup for R6..R10
    wr(A_CMP + 0, 4);
    wr(A_CMP + 1, 2);
    wr(A_CMP + 2, 3);
    wr(A_CMP + 3, 9);
    wr(A_CMP + 4, 2);
    wr(A_ACT, 'h43F3);
    wr(A_MASK, 'h0E);
    wr(A_LVL, 'h02);
    wr(A_MODE, 'h8F);
    wr(A_CMP + 7, 9);
    wr(A_CTRL, 1 | 2);
    repeat (25) @(negedge clk);
    expectPeriods(10, 2);

    waitCount(6);
    check("R7 set action ch0", int'(pinOut[0]), 1);
    check("R7 set action ch2", int'(pinOut[2]), 1);
    check("R10 ch3 held by master level", int'(pinOut[3]), 0);
    check("R8 disconnected masked ch1", int'(pinOut[1]), 0);
    check("R6 mode-0 ch4 pin", int'(pinOut[4]), 0);
    rd(A_FLAG, v);
    check("R6 mode-0 ch4 flag", (v >> 4) & 1, 0);
    check("R6 ch0 flag set", v & 1, 1);

    waitCount(9);
    check("R9 broadcast clears ch2", int'(pinOut[2]), 0);
    check("R10 same-cycle priority ch3", int'(pinOut[3]), 0);
    check("R8 broadcast level ignored ch1", int'(pinOut[1]), 0);
    rd(A_FLAG, v);
    check("R6 master flag", (v >> 7) & 1, 1);

    // R11 flag clearing, count sits away from channel 0 value
    waitCount(6);
    wr(A_FLAG, 0);
    rd(A_FLAG, v);
    check("R11 write 0 keeps flag", v & 1, 1);
    wr(A_FLAG, 1);
    rd(A_FLAG, v);
    check("R11 write 1 clears flag", v & 1, 0);
    waitCount(5);
    rd(A_FLAG, v);
    check("R6 flag sets again on match", v & 1, 1);

    // R7 clear action on channel 0
    wr(A_ACT, 'h43F2);
    waitCount(6);
    check("R7 clear action ch0", int'(pinOut[0]), 0);

    // R2/R3 free-running prescale
    wr(A_CTRL, 1);
    rd(A_CNT, c1); repeat (20) @(negedge clk); rd(A_CNT, c2);
    check("R3 N=0 steps", c2 - c1, 20);
    wr(A_CTRL, 1 | (2 << 2));
    rd(A_CNT, c1); repeat (40) @(negedge clk); rd(A_CNT, c2);
    check("R3 N=2 steps", c2 - c1, 10);
    wr(A_CTRL, 1 | (7 << 2));
    rd(A_CNT, c1); repeat (256) @(negedge clk); rd(A_CNT, c2);
    check("R3 N=7 steps", c2 - c1, 2);
    rd(A_CTRL, v);
    check("R2 control readback", v, 1 | (7 << 2));
    wr(A_CTRL, 0);
    rd(A_CNT, c1); repeat (30) @(negedge clk); rd(A_CNT, c2);
    check("R3 disabled hold", c2 - c1, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule